// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity inside an accelerator so software can measure it. It holds one 48-bit cycle counter and a parameterised array of 32-bit event counters, four by default. Each event counter follows one event code, and event sources arrive as a vector of single-cycle pulses with one bit per code. A simple register port with write strobe, word address and combinational read data carries all control and status.

Per-counter enables, overflow flags and interrupt enables are each changed through a pair of write-one-to-set and write-one-to-clear registers. In all three masks, bit 31 belongs to the cycle counter and bits 3:0 belong to event counters 0 to 3. The cycle counter can be armed so that it runs only between a start event and a stop event. An interrupt output is raised while any overflow flag is set whose interrupt is also enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: Bit 0 of the control register (word 0x00) is the master enable and resets to 0. While it is 0, no counter advances, whatever pulses or per-counter enables are present.
- R2: Writing a 1 to control bit 1 clears the cycle counter, and writing a 1 to control bit 2 clears every event counter. Both bits read back as 0, and each leaves the other kind of counter untouched.
- R3: The cycle counter is 48 bits wide. Its bits 31:0 are at word 0x07 and its bits 47:32 are at word 0x08, in data bits 15:0 with the upper data bits reading 0. Both words are writable. When enabled it advances once per clock, and a carry out of the low word moves into the high word.
- R4: Event counter n is at word 0x10+n and its event-type register is at word 0x18+n. Both are readable and writable. The counter advances by one on each clock in which `evt_pulse_i[code]` is high, where code is the value in its type register. Code 0 never counts.
- R5: Writing a mask to word 0x01 enables the counters whose bits are 1, and writing a mask to word 0x02 disables them. Reading either word returns the enable mask. Only bit 31 and bits 3:0 exist; all other bits read 0.
- R6: When a counter advances from all ones to zero, its overflow bit sets. The overflow bits read at word 0x03, and writes to that word are ignored. Writing ones to word 0x04 clears the matching bits, but a wrap in the same cycle keeps its bit set.
- R7: Interrupt enables are set through word 0x05 and cleared through word 0x06, and both words read back the enables. `irq_o` is high exactly while some overflow bit and its interrupt enable are both 1.
- R8: The cycle configuration at word 0x09 holds the start code in bits 5:0 and the stop code in bits 21:16, and a write there replaces both. A write to word 0x0A changes only the start code, and a write to word 0x0B changes only the stop code, each taken from data bits 5:0.
- R9: With a nonzero start code, the cycle counter counts only after a start pulse and up to the next stop pulse. If the start pulse is sampled at clock edge E and the stop pulse at edge E+k, it advances exactly k times. With start code 0 it runs whenever it is enabled.
- R10: A register write to a counter, or a reset bit aimed at it, takes precedence over an increment in the same cycle. The counter then holds exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current address |
| evt_pulse_i | input | 64 | Event pulses, indexed by event code |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A counter that advances in the wrong cycle shows up directly in its read-back value as an off-by-one. Because the bench freezes the counters by dropping the master enable before it reads, the error appears at the first read after the scenario. A wrong run state in the start/stop gate changes the cycle count by the whole gated window, so it shows at the same read. A lost or stuck overflow bit shows on `irq_o` as soon as the matching interrupt enable is set, with no clock edge in between.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 32;
   localparam int CYC_BIT = 31;

   localparam logic [ADDR_W-1:0] A_CTRL      = 6'h00;
   localparam logic [ADDR_W-1:0] A_EN_SET    = 6'h01;
   localparam logic [ADDR_W-1:0] A_EN_CLR    = 6'h02;
   localparam logic [ADDR_W-1:0] A_OVF_STAT  = 6'h03;
   localparam logic [ADDR_W-1:0] A_OVF_CLR   = 6'h04;
   localparam logic [ADDR_W-1:0] A_IRQ_SET   = 6'h05;
   localparam logic [ADDR_W-1:0] A_IRQ_CLR   = 6'h06;
   localparam logic [ADDR_W-1:0] A_CYC_LO    = 6'h07;
   localparam logic [ADDR_W-1:0] A_CYC_HI    = 6'h08;
   localparam logic [ADDR_W-1:0] A_CYC_CFG   = 6'h09;
   localparam logic [ADDR_W-1:0] A_CYC_START = 6'h0A;
   localparam logic [ADDR_W-1:0] A_CYC_STOP  = 6'h0B;
   localparam logic [ADDR_W-1:0] A_EVCNT     = 6'h10;
   localparam logic [ADDR_W-1:0] A_EVTYPE    = 6'h18;

   localparam int CTRL_ENABLE  = 0;
   localparam int CTRL_CYC_RST = 1;
   localparam int CTRL_EVT_RST = 2;
   localparam int CFG_STOP_LSB = 16;
endpackage

// File: rtl/pmu_mask_reg.sv
module pmu_mask_reg #(
   parameter int          W    = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] hw_set_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_q;
   logic [W-1:0] set_m, clr_m;

   assign set_m = set_i ? wdata_i : '0;
   assign clr_m = clr_i ? wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= (((q_q | set_m) & ~clr_m) | hw_set_i) & IMPL;
   end

   assign q_o = q_q;

   a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> ((q_o & $past(wdata_i & ~hw_set_i)) == '0));
endmodule

// File: rtl/pmu_evt_cnt.sv
module pmu_evt_cnt #(
   parameter int CNT_W  = 32,
   parameter int CODE_W = 6,
   localparam int NCODE = 1 << CODE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              count_en_i,
   input  logic [NCODE-1:0]  evt_i,
   input  logic              type_we_i,
   input  logic              cnt_we_i,
   input  logic              clr_i,
   input  logic [31:0]       wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CODE_W-1:0] type_o,
   output logic              wrap_o
);
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] type_q;
   logic              hit;

   if (CNT_W > 32 || CNT_W < 2) begin : g_bad_width
      $error("pmu_evt_cnt: CNT_W must lie in 2..32");
   end

   assign hit    = count_en_i && (type_q != '0) && evt_i[type_q];
   assign wrap_o = hit && (&cnt_q) && !cnt_we_i && !clr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         type_q <= '0;
      end else begin
         if (type_we_i) type_q <= wdata_i[CODE_W-1:0];
         if (clr_i)         cnt_q <= '0;
         else if (cnt_we_i) cnt_q <= wdata_i[CNT_W-1:0];
         else if (hit)      cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign type_o = type_q;

   a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!count_en_i && !cnt_we_i && !clr_i) |=> $stable(cnt_q));
   a_r6_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pmu_cyc_cnt.sv
module pmu_cyc_cnt #(
   parameter int CYC_W     = 48,
   parameter int CODE_W    = 6,
   parameter bit CYC_GATED = 1'b1,
   localparam int NCODE = 1 << CODE_W,
   localparam int HI_W  = CYC_W - 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              count_en_i,
   input  logic [NCODE-1:0]  evt_i,
   input  logic [CODE_W-1:0] start_code_i,
   input  logic [CODE_W-1:0] stop_code_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic              clr_i,
   input  logic [31:0]       wdata_i,
   output logic [CYC_W-1:0]  cyc_o,
   output logic              wrap_o
);
   logic [CYC_W-1:0] cyc_q;
   logic             gate;
   logic             tick;
   logic             any_wr;

   if (CYC_W <= 32 || CYC_W > 64) begin : g_bad_width
      $error("pmu_cyc_cnt: CYC_W must lie in 33..64");
   end

   if (CYC_GATED) begin : g_gate
      logic run_q;
      logic start_hit, stop_hit;
      assign start_hit = (start_code_i != '0) && evt_i[start_code_i];
      assign stop_hit  = (stop_code_i  != '0) && evt_i[stop_code_i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        run_q <= 1'b0;
         else if (stop_hit)  run_q <= 1'b0;
         else if (start_hit) run_q <= 1'b1;
      end
      assign gate = (start_code_i == '0) || run_q;

      a_r9_closed_gate_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((start_code_i != '0) && !run_q && !wr_lo_i && !wr_hi_i && !clr_i) |=> $stable(cyc_q));
   end else begin : g_free
      assign gate = 1'b1;
   end

   assign any_wr = wr_lo_i || wr_hi_i || clr_i;
   assign tick   = count_en_i && gate;
   assign wrap_o = tick && (&cyc_q) && !any_wr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cyc_q <= '0;
      else if (clr_i)   cyc_q <= '0;
      else if (wr_lo_i) cyc_q[31:0] <= wdata_i;
      else if (wr_hi_i) cyc_q[CYC_W-1:32] <= wdata_i[HI_W-1:0];
      else if (tick)    cyc_q <= cyc_q + 1'b1;
   end

   assign cyc_o = cyc_q;

   a_r1_cyc_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!count_en_i && !any_wr) |=> $stable(cyc_q));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
   import pmu_pkg::*;
#(
   parameter int NUM_EVT   = 4,
   parameter int CODE_W    = 6,
   parameter int CYC_W     = 48,
   parameter bit CYC_GATED = 1'b1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     reg_we_i,
   input  logic [ADDR_W-1:0]        reg_addr_i,
   input  logic [DATA_W-1:0]        reg_wdata_i,
   output logic [DATA_W-1:0]        reg_rdata_o,
   input  logic [(1<<CODE_W)-1:0]   evt_pulse_i,
   output logic                     irq_o
);
   localparam int NCODE = 1 << CODE_W;
   localparam logic [DATA_W-1:0] IMPL_MASK =
      (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_EVT) - DATA_W'(1));

   if (NUM_EVT < 1 || NUM_EVT > 8) begin : g_bad_num
      $error("perf_mon_unit: NUM_EVT must lie in 1..8");
   end
   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
      $error("perf_mon_unit: CODE_W must lie in 1..16");
   end

   logic              master_q;
   logic [CODE_W-1:0] start_q, stop_q;
   logic [DATA_W-1:0] en_q, ovf_q, irqen_q, ovf_hw;
   logic [CYC_W-1:0]  cyc_val;
   logic              cyc_wrap;
   logic [31:0]       evt_cnt  [NUM_EVT];
   logic [CODE_W-1:0] evt_type [NUM_EVT];
   logic [NUM_EVT-1:0] evt_wrap;

   logic wr_ctrl, clr_cyc, clr_evt;

   assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
   assign clr_cyc = wr_ctrl && reg_wdata_i[CTRL_CYC_RST];
   assign clr_evt = wr_ctrl && reg_wdata_i[CTRL_EVT_RST];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         master_q <= 1'b0;
         start_q  <= '0;
         stop_q   <= '0;
      end else if (reg_we_i) begin
         unique case (reg_addr_i)
            A_CTRL:      master_q <= reg_wdata_i[CTRL_ENABLE];
            A_CYC_CFG: begin
               start_q <= reg_wdata_i[CODE_W-1:0];
               stop_q  <= reg_wdata_i[CFG_STOP_LSB +: CODE_W];
            end
            A_CYC_START: start_q <= reg_wdata_i[CODE_W-1:0];
            A_CYC_STOP:  stop_q  <= reg_wdata_i[CODE_W-1:0];
            default: ;
         endcase
      end
   end

   // paired set/clear masks
   pmu_mask_reg #(.W(DATA_W), .IMPL(IMPL_MASK)) u_en (
      .clk_i, .rst_ni,
      .set_i(reg_we_i && reg_addr_i == A_EN_SET),
      .clr_i(reg_we_i && reg_addr_i == A_EN_CLR),
      .wdata_i(reg_wdata_i), .hw_set_i('0), .q_o(en_q));

   pmu_mask_reg #(.W(DATA_W), .IMPL(IMPL_MASK)) u_ovf (
      .clk_i, .rst_ni,
      .set_i(1'b0),
      .clr_i(reg_we_i && reg_addr_i == A_OVF_CLR),
      .wdata_i(reg_wdata_i), .hw_set_i(ovf_hw), .q_o(ovf_q));

   pmu_mask_reg #(.W(DATA_W), .IMPL(IMPL_MASK)) u_irqen (
      .clk_i, .rst_ni,
      .set_i(reg_we_i && reg_addr_i == A_IRQ_SET),
      .clr_i(reg_we_i && reg_addr_i == A_IRQ_CLR),
      .wdata_i(reg_wdata_i), .hw_set_i('0), .q_o(irqen_q));

   pmu_cyc_cnt #(.CYC_W(CYC_W), .CODE_W(CODE_W), .CYC_GATED(CYC_GATED)) u_cyc (
      .clk_i, .rst_ni,
      .count_en_i(master_q && en_q[CYC_BIT]),
      .evt_i(evt_pulse_i),
      .start_code_i(start_q), .stop_code_i(stop_q),
      .wr_lo_i(reg_we_i && reg_addr_i == A_CYC_LO),
      .wr_hi_i(reg_we_i && reg_addr_i == A_CYC_HI),
      .clr_i(clr_cyc), .wdata_i(reg_wdata_i),
      .cyc_o(cyc_val), .wrap_o(cyc_wrap));

   for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
      pmu_evt_cnt #(.CNT_W(32), .CODE_W(CODE_W)) u_cnt (
         .clk_i, .rst_ni,
         .count_en_i(master_q && en_q[n]),
         .evt_i(evt_pulse_i),
         .type_we_i(reg_we_i && reg_addr_i == (A_EVTYPE + ADDR_W'(n))),
         .cnt_we_i(reg_we_i && reg_addr_i == (A_EVCNT + ADDR_W'(n))),
         .clr_i(clr_evt), .wdata_i(reg_wdata_i),
         .cnt_o(evt_cnt[n]), .type_o(evt_type[n]), .wrap_o(evt_wrap[n]));

      a_r6_evt_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
         evt_wrap[n] |=> ovf_q[n]);
   end

   always_comb begin
      ovf_hw = '0;
      ovf_hw[NUM_EVT-1:0] = evt_wrap;
      ovf_hw[CYC_BIT] = cyc_wrap;
   end

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_addr_i)
         A_CTRL:                  reg_rdata_o[CTRL_ENABLE] = master_q;
         A_EN_SET, A_EN_CLR:      reg_rdata_o = en_q;
         A_OVF_STAT:              reg_rdata_o = ovf_q;
         A_IRQ_SET, A_IRQ_CLR:    reg_rdata_o = irqen_q;
         A_CYC_LO:                reg_rdata_o = cyc_val[31:0];
         A_CYC_HI:                reg_rdata_o = DATA_W'(cyc_val[CYC_W-1:32]);
         A_CYC_CFG: begin
            reg_rdata_o[CODE_W-1:0] = start_q;
            reg_rdata_o[CFG_STOP_LSB +: CODE_W] = stop_q;
         end
         default: ;
      endcase
      for (int n = 0; n < NUM_EVT; n++) begin
         if (reg_addr_i == (A_EVCNT + ADDR_W'(n)))  reg_rdata_o = evt_cnt[n];
         if (reg_addr_i == (A_EVTYPE + ADDR_W'(n))) reg_rdata_o = DATA_W'(evt_type[n]);
      end
   end

   assign irq_o = |(ovf_q & irqen_q);

   a_r6_cyc_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cyc_wrap |=> ovf_q[CYC_BIT]);
   a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q == '0) |-> !irq_o);
endmodule

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [63:0] evt = '0;
   logic        irq;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perf_mon_unit u_perf_mon_unit (
      .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_pulse_i(evt), .irq_o(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      addr = a; #1;
      check(req, rdata, exp);
   endtask

   task automatic pulse(input int code);
      evt[code] = 1'b1;
      @(negedge clk);
      evt[code] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk("R1 ctrl reset", 6'h00, 32'h0);
      rd_chk("R5 enable reset", 6'h01, 32'h0);
      rd_chk("R6 ovf reset", 6'h03, 32'h0);
      rd_chk("R3 cycle reset", 6'h07, 32'h0);
      check("R7 irq reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_mask;
      wr(6'h01, 32'hFFFF_FFFF);
      rd_chk("R5 set all", 6'h01, 32'h8000_000F);
      wr(6'h02, 32'h8000_0001);
      rd_chk("R5 clear bits", 6'h02, 32'h0000_000E);
   endtask

   task automatic t_events;
      wr(6'h01, 32'h8000_0007);
      wr(6'h02, 32'h0000_0004);
      rd_chk("R5 mask", 6'h01, 32'h8000_000B);
      wr(6'h18, 32'd5); wr(6'h19, 32'd0); wr(6'h1A, 32'd5); wr(6'h1B, 32'd9);
      rd_chk("R4 type readback", 6'h18, 32'd5);
      wr(6'h00, 32'h1);
      repeat (3) pulse(5);
      repeat (2) pulse(0);
      wr(6'h00, 32'h0);
      rd_chk("R4 counts code 5", 6'h10, 32'd3);
      rd_chk("R4 code zero never counts", 6'h11, 32'd0);
      rd_chk("R5 disabled counter", 6'h12, 32'd0);
      rd_chk("R4 other code", 6'h13, 32'd0);
   endtask

   task automatic t_master_off;
      logic [31:0] lo;
      addr = 6'h07; #1; lo = rdata;
      repeat (3) pulse(5);
      idle(4);
      rd_chk("R1 event held", 6'h10, 32'd3);
      rd_chk("R1 cycle held", 6'h07, lo);
   endtask

   task automatic t_resets;
      logic [31:0] lo;
      addr = 6'h07; #1; lo = rdata;
      check("R2 cycle nonzero before", {31'b0, lo != 0}, 32'h1);
      wr(6'h00, 32'h4);
      rd_chk("R2 event reset", 6'h10, 32'd0);
      rd_chk("R2 cycle untouched", 6'h07, lo);
      wr(6'h00, 32'h2);
      rd_chk("R2 cycle reset", 6'h07, 32'd0);
      rd_chk("R2 reset bits read zero", 6'h00, 32'd0);
   endtask

   task automatic t_cycle;
      wr(6'h08, 32'hABCD_1234);
      wr(6'h07, 32'hFFFF_FFF0);
      rd_chk("R3 high word", 6'h08, 32'h0000_1234);
      rd_chk("R3 low word", 6'h07, 32'hFFFF_FFF0);
      wr(6'h00, 32'h1);
      idle(18);
      wr(6'h00, 32'h0);
      rd_chk("R3 low after carry", 6'h07, 32'h0000_0004);
      rd_chk("R3 high after carry", 6'h08, 32'h0000_1235);
      rd_chk("R6 no ovf on carry", 6'h03, 32'h0);
   endtask

   task automatic t_overflow;
      wr(6'h10, 32'hFFFF_FFFE);
      wr(6'h00, 32'h1);
      pulse(5); pulse(5);
      wr(6'h00, 32'h0);
      rd_chk("R6 counter wrapped", 6'h10, 32'h0);
      rd_chk("R6 ovf bit0", 6'h03, 32'h1);
      wr(6'h03, 32'h8000_0000);
      rd_chk("R6 status write ignored", 6'h03, 32'h1);
      check("R7 irq masked", {31'b0, irq}, 32'h0);
      wr(6'h05, 32'h1);
      rd_chk("R7 irq enable readback", 6'h06, 32'h1);
      check("R7 irq raised", {31'b0, irq}, 32'h1);
      wr(6'h06, 32'h1);
      check("R7 irq disabled", {31'b0, irq}, 32'h0);
      wr(6'h05, 32'h1);
      wr(6'h04, 32'h1);
      rd_chk("R6 ovf cleared", 6'h03, 32'h0);
      check("R7 irq after clear", {31'b0, irq}, 32'h0);
      wr(6'h08, 32'h0000_FFFF);
      wr(6'h07, 32'hFFFF_FFFE);
      wr(6'h00, 32'h1);
      wr(6'h00, 32'h0);
      rd_chk("R6 cycle wrapped", 6'h07, 32'h0);
      rd_chk("R6 cycle ovf bit31", 6'h03, 32'h8000_0000);
      wr(6'h04, 32'h8000_0000);
      rd_chk("R6 cycle ovf cleared", 6'h03, 32'h0);
   endtask

   task automatic t_config;
      wr(6'h09, 32'h0007_0003);
      rd_chk("R8 both fields", 6'h09, 32'h0007_0003);
      wr(6'h0A, 32'd9);
      rd_chk("R8 start only", 6'h09, 32'h0007_0009);
      wr(6'h0B, 32'd12);
      rd_chk("R8 stop only", 6'h09, 32'h000C_0009);
      wr(6'h09, 32'h0007_0003);
   endtask

   task automatic t_gating;
      wr(6'h00, 32'h2);
      wr(6'h00, 32'h1);
      idle(5);
      rd_chk("R9 waits for start", 6'h07, 32'd0);
      pulse(3);
      idle(6);
      pulse(7);
      idle(5);
      wr(6'h00, 32'h0);
      rd_chk("R9 counted window", 6'h07, 32'd7);
   endtask

   task automatic t_precedence;
      wr(6'h00, 32'h1);
      @(negedge clk);
      evt[5] = 1'b1; we = 1'b1; addr = 6'h10; wdata = 32'd100;
      @(negedge clk);
      evt[5] = 1'b0; we = 1'b0;
      wr(6'h00, 32'h0);
      rd_chk("R10 write beats increment", 6'h10, 32'd100);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset;
      t_mask;
      t_events;
      t_master_off;
      t_resets;
      t_cycle;
      t_overflow;
      t_config;
      t_gating;
      t_precedence;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule